// File: doc/BRIEF.md
# Modular phase-position remapper

A phase-locked loop whose feedback divider M is not a power of two rotates the phase positions it receives. If the reference phase generator resolves a full turn into 2^K steps, then input position i leaves the loop at position (n·i) mod 2^K, where n = M mod 2^K. This block undoes that rotation. A controller gives it the divider value and the output position it wants. The block returns the input phase word that must be programmed to reach that output position.

On a start strobe the block registers M and finds the multiplicative inverse of n modulo 2^K. It tries one candidate per clock, beginning at zero, and keeps the first value whose product with n is 1 modulo 2^K. It then multiplies the inverse by the wanted output position.

When M is even the inverse does not exist and some output positions can never be reached. In that case the block raises an error flag, returns zero, and reports how many distinct output positions remain. Once an inverse is cached, each convert strobe that carries the same M returns a new input word on the next cycle.

Top module: `phase_pos_remap`

## Requirements
- R1: During reset and after it, `done`, `busy`, `even_err`, `in_pos` and `pos_count` are all zero until the first start.
- R2: After a `start` with an odd M, `busy` is high during the search. Exactly one `done` pulse appears after the (1 + inverse)-th rising edge that follows the start edge. This is never more than 2^K edges. `busy` and `done` are never high together.
- R3: With an odd M, the `in_pos` shown with `done` equals (inverse · L_OUT) mod 2^K. Here the inverse is the unique value in 0..2^K−1 with (inverse · n) mod 2^K = 1, and n is the low K bits of `div_m`. As a result, (n · `in_pos`) mod 2^K equals the requested L_OUT.
- R4: With K = 6, M = 2001 and L_OUT = 5, the result is `in_pos` = 53. The inverse is 49, so `done` is due 50 edges after the start edge.
- R5: With K = 4, M = 19 and L_OUT = 7, the result is `in_pos` = 13 (n = 3, inverse 11), with `pos_count` = 16.
- R6: A `start` with an even M gives `done` at the first edge. `even_err` = 1, `in_pos` = 0, and `pos_count` = 2^K >> min(trailing zeros of M, K). M = 0 therefore gives a count of 1.
- R7: In the ready state, a `conv` strobe whose `div_m` equals the registered M gives `done` at the next edge, with `in_pos` = (cached inverse · `tgt_pos`) mod 2^K. It gives 0 if the registered M was even. `busy` stays low.
- R8: In the ready state, a `conv` strobe whose `div_m` differs from the registered M acts as a `start` with that M and `tgt_pos`.
- R9: A `conv` strobe before any start, or while a search runs, is ignored. It produces no `done` pulse, it leaves `in_pos` unchanged, and it does not alter the pending result.
- R10: A `start` while a search is running discards that search. It restarts with the new M and `tgt_pos`, timed from the new start edge.
- R11: With an odd M, `pos_count` is 2^K and `even_err` is 0 when `done` is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Register `div_m` and `tgt_pos`, then begin a search |
| conv | input | 1 | Convert `tgt_pos` with the cached inverse |
| div_m | input | MW | Loop feedback divider value M |
| tgt_pos | input | K | Wanted output phase position L_OUT |
| in_pos | output | K | Input phase word to program |
| done | output | 1 | One-cycle pulse: `in_pos`, `even_err` and `pos_count` are valid |
| busy | output | 1 | Inverse search in progress |
| even_err | output | 1 | Registered M is even; positions are lost |
| pos_count | output | K+1 | Number of reachable output positions |

## Verification
Each result has a due cycle, and the due cycle depends on the kind of stimulus. An even M is due one edge after the start. A same-M conversion is due one edge after the strobe. An odd-M search is due 1 + inverse edges after the start, where the bench derives the inverse by Newton iteration and not by search. The driver stamps every expected item with its due cycle. The monitor samples on falling edges and fails any `done` that arrives early, late, or with nothing queued. Ignored strobes are covered the same way: a `done` pulse that the bench did not expect is a failure, and `in_pos` is compared before and after the strobe.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SRCH,
    ST_RDY
  } st_e;

  // product of a and b reduced modulo 2^k (k below 32)
  function automatic logic [31:0] mod_mul(input logic [31:0] a, input logic [31:0] b,
                                          input int k);
    logic [31:0] p;
    p = a * b;
    return p & ((32'd1 << k) - 32'd1);
  endfunction

  // count of trailing zero bits of v, saturated at cap (v == 0 gives cap)
  function automatic int trail_zeros(input logic [31:0] v, input int cap);
    int r;
    r = cap;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    if (r > cap) r = cap;
    return r;
  endfunction

endpackage

// File: rtl/ppr_divider_info.sv
module ppr_divider_info #(
  parameter int K  = 6,
  parameter int MW = 16
) (
  input  logic [MW-1:0] div_m,
  output logic [K-1:0]  res_n,
  output logic          is_even,
  output logic [K:0]    count
);
  import ppr_pkg::*;

  localparam logic [K:0] FULL_SET = (K+1)'(1) << K;

  int tz;

  always_comb begin
    res_n   = div_m[K-1:0];
    is_even = ~div_m[0];
    tz      = trail_zeros(32'(div_m), K);
    count   = FULL_SET >> tz;
  end

endmodule

// File: rtl/ppr_inv_search.sv
module ppr_inv_search #(
  parameter int K = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  input  logic [K-1:0] n_in,
  output logic [K-1:0] cand,
  output logic         hit
);
  import ppr_pkg::*;

  logic [31:0] prod;

  always_comb begin
    prod = mod_mul(32'(cand), 32'(n_in), K);
    hit  = (prod == 32'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cand <= '0;
    else if (clear) cand <= '0;
    else if (adv)   cand <= cand + 1'b1;
  end

endmodule

// File: rtl/phase_pos_remap.sv
module phase_pos_remap #(
  parameter int K  = 6,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          conv,
  input  logic [MW-1:0] div_m,
  input  logic [K-1:0]  tgt_pos,
  output logic [K-1:0]  in_pos,
  output logic          done,
  output logic          busy,
  output logic          even_err,
  output logic [K:0]    pos_count
);
  import ppr_pkg::*;

  st_e           st_q;
  logic [MW-1:0] m_q;
  logic [K-1:0]  n_q;
  logic [K-1:0]  tgt_q;
  logic [K-1:0]  inv_q;

  logic [K-1:0]  info_n;
  logic          info_even;
  logic [K:0]    info_count;
  logic [K-1:0]  cand;
  logic          hit;

  // named internal events, also used by the bound checker
  logic ready;
  logic m_same;
  logic conv_rdy;
  logic launch;
  logic search_hit;

  assign ready      = (st_q == ST_RDY);
  assign busy       = (st_q == ST_SRCH);
  assign m_same     = (div_m == m_q);
  assign conv_rdy   = conv & ready & ~start;
  assign launch     = start | (conv_rdy & ~m_same);
  assign search_hit = busy & hit & ~start;

  ppr_divider_info #(.K(K), .MW(MW)) u_info (
    .div_m   (div_m),
    .res_n   (info_n),
    .is_even (info_even),
    .count   (info_count)
  );

  ppr_inv_search #(.K(K)) u_search (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .adv   (busy & ~hit),
    .n_in  (n_q),
    .cand  (cand),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      m_q       <= '0;
      n_q       <= '0;
      tgt_q     <= '0;
      inv_q     <= '0;
      in_pos    <= '0;
      done      <= 1'b0;
      even_err  <= 1'b0;
      pos_count <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        m_q       <= div_m;
        n_q       <= info_n;
        tgt_q     <= tgt_pos;
        pos_count <= info_count;
        if (info_even) begin
          even_err <= 1'b1;
          inv_q    <= '0;
          in_pos   <= '0;
          done     <= 1'b1;
          st_q     <= ST_RDY;
        end else begin
          even_err <= 1'b0;
          st_q     <= ST_SRCH;
        end
      end else if (search_hit) begin
        inv_q  <= cand;
        in_pos <= K'(mod_mul(32'(cand), 32'(tgt_q), K));
        done   <= 1'b1;
        st_q   <= ST_RDY;
      end else if (conv_rdy) begin
        tgt_q  <= tgt_pos;
        in_pos <= even_err ? '0 : K'(mod_mul(32'(inv_q), 32'(tgt_pos), K));
        done   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ppr_checker.sv
module ppr_checker #(
  parameter int K = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         conv,
  input logic         div_lsb,
  input logic         done,
  input logic         busy,
  input logic         ready,
  input logic         m_same,
  input logic         even_err,
  input logic [K-1:0] in_pos,
  input logic [K-1:0] n_q,
  input logic [K-1:0] tgt_q,
  input logic [K:0]   pos_count
);
  import ppr_pkg::*;

  localparam logic [K:0] FULL_SET = (K+1)'(1) << K;

  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || start) run_len <= 0;
    else                          run_len <= run_len + 1;
  end

  AST_RESULT_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !even_err) |-> (mod_mul(32'(n_q), 32'(in_pos), K) == 32'(tgt_q))); // R3
  AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < (1 << K))); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && !busy)); // R2
  AST_EVEN_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !div_lsb) |=> (done && even_err)); // R6
  AST_EVEN_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && even_err) |-> (in_pos == '0 && pos_count < FULL_SET)); // R6
  AST_CONV_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && ready && !start && m_same) |=> (done && !busy)); // R7
  AST_ODD_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !even_err) |-> (pos_count == FULL_SET)); // R11

endmodule

bind phase_pos_remap ppr_checker #(.K(K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .conv      (conv),
  .div_lsb   (div_m[0]),
  .done      (done),
  .busy      (busy),
  .ready     (ready),
  .m_same    (m_same),
  .even_err  (even_err),
  .in_pos    (in_pos),
  .n_q       (n_q),
  .tgt_q     (tgt_q),
  .pos_count (pos_count)
);

// File: tb/tb_phase_pos_remap.sv
module tb_phase_pos_remap;

  localparam int K  = 6;
  localparam int MW = 16;
  localparam int NP = 1 << K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0, conv = 1'b0;
  logic [MW-1:0] div_m = '0;
  logic [K-1:0]  tgt_pos = '0;
  logic [K-1:0]  in_pos;
  logic          done, busy, even_err;
  logic [K:0]    pos_count;

  phase_pos_remap #(.K(K), .MW(MW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .conv(conv), .div_m(div_m),
    .tgt_pos(tgt_pos), .in_pos(in_pos), .done(done), .busy(busy),
    .even_err(even_err), .pos_count(pos_count)
  );

  logic          s4 = 1'b0;
  logic [MW-1:0] m4 = '0;
  logic [3:0]    t4 = '0;
  logic [3:0]    p4;
  logic          d4, b4, e4;
  logic [4:0]    c4;

  phase_pos_remap #(.K(4), .MW(MW)) dut_k4 (
    .clk(clk), .rst_n(rst_n), .start(s4), .conv(1'b0), .div_m(m4),
    .tgt_pos(t4), .in_pos(p4), .done(d4), .busy(b4),
    .even_err(e4), .pos_count(c4)
  );

  typedef struct {
    logic [K-1:0] pos;
    logic         err;
    logic [K:0]   cnt;
    int           due;
    string        req;
  } item_t;

  item_t sb[$];
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // inverse of odd n modulo 2^K by Newton iteration
  function automatic int inv_mod(input int n);
    logic [31:0] x;
    x = 32'(n);
    for (int i = 0; i < 5; i++) x = x * (32'd2 - 32'(n) * x);
    return int'(x & 32'(NP - 1));
  endfunction

  function automatic int reach_count(input int m);
    int g;
    g = 1;
    while (g < NP && (m % (2 * g)) == 0) g = g * 2;
    return NP / g;
  endfunction

  function automatic item_t model(input int m, input int t, input int base, input string req);
    item_t it;
    int n, iv;
    n = m % NP;
    it.req = req;
    it.cnt = (K+1)'(reach_count(m));
    if (m % 2 == 0) begin
      it.err = 1'b1; it.pos = '0; it.due = base + 1;
    end else begin
      iv = inv_mod(n);
      it.err = 1'b0; it.pos = K'((iv * t) % NP); it.due = base + 2 + iv;
    end
    return it;
  endfunction

  // monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R9 unexpected done: actual in_pos %0d expected no result", in_pos);
      end else begin
        item_t e;
        e = sb.pop_front();
        chk(e.req, cyc, e.due, "done cycle");
        chk(e.req, int'(in_pos), int'(e.pos), "in_pos");
        chk(e.req, int'(even_err), int'(e.err), "even_err");
        chk(e.req, int'(pos_count), int'(e.cnt), "pos_count");
      end
    end
  end

  task automatic wait_empty();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_start(input int m, input int t, input string req);
    @(negedge clk);
    sb.push_back(model(m, t, cyc, req));
    div_m = MW'(m); tgt_pos = K'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_empty();
  endtask

  task automatic do_conv_same(input int m, input int t, input int inv_v, input string req);
    item_t it;
    @(negedge clk);
    it.req = req;
    it.err = (m % 2 == 0);
    it.cnt = (K+1)'(reach_count(m));
    it.pos = it.err ? '0 : K'((inv_v * t) % NP);
    it.due = cyc + 1;
    sb.push_back(it);
    div_m = MW'(m); tgt_pos = K'(t); conv = 1'b1;
    @(negedge clk);
    conv = 1'b0;
    chk("R7", int'(busy), 0, "busy after conv");
    wait_empty();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [K-1:0] held;
    repeat (3) @(negedge clk);
    chk("R1", int'(done), 0, "done in reset");
    chk("R1", int'(busy), 0, "busy in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(in_pos), 0, "in_pos after reset");
    chk("R1", int'(even_err), 0, "even_err after reset");
    chk("R1", int'(pos_count), 0, "pos_count after reset");

    // R9: convert before any start must do nothing
    conv = 1'b1; tgt_pos = 6'd9; div_m = 16'd7;
    @(negedge clk);
    conv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", int'(in_pos), 0, "in_pos after idle conv");

    // R4: required vector, also R2 timing and R11 count
    do_start(2001, 5, "R4");
    do_conv_same(2001, 63, 49, "R7");
    do_conv_same(2001, 0, 49, "R7");
    do_start(1, 9, "R3");
    do_start(63, 33, "R2");
    do_start(45, 22, "R11");

    // R6: even dividers
    do_start(12, 7, "R6");
    do_start(0, 3, "R6");
    do_start(128, 3, "R6");
    do_start(2, 1, "R6");
    do_conv_same(2, 40, 0, "R7");

    // R8: conv with a new divider acts as start
    @(negedge clk);
    sb.push_back(model(3, 1, cyc, "R8"));
    div_m = 16'd3; tgt_pos = 6'd1; conv = 1'b1;
    @(negedge clk);
    conv = 1'b0;
    wait_empty();

    // R9: conv during a search is ignored
    @(negedge clk);
    sb.push_back(model(2001, 11, cyc, "R9"));
    div_m = 16'd2001; tgt_pos = 6'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    held = in_pos;
    div_m = 16'd2001; tgt_pos = 6'd30; conv = 1'b1;
    @(negedge clk);
    conv = 1'b0;
    chk("R9", int'(in_pos), int'(held), "in_pos after conv in search");
    wait_empty();

    // R10: restart abandons the running search
    @(negedge clk);
    div_m = 16'd63; tgt_pos = 6'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    sb.push_back(model(5, 17, cyc, "R10"));
    div_m = 16'd5; tgt_pos = 6'd17; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_empty();

    // R5: K = 4 instance
    @(negedge clk);
    m4 = 16'd19; t4 = 4'd7; s4 = 1'b1;
    @(negedge clk);
    s4 = 1'b0;
    for (int i = 0; i < 40 && !d4; i++) @(negedge clk);
    chk("R5", int'(d4), 1, "done k4");
    chk("R5", int'(p4), 13, "in_pos k4");
    chk("R5", int'(c4), 16, "pos_count k4");
    chk("R5", int'(e4), 0, "even_err k4");
    chk("R5", int'(b4), 0, "busy k4");

    repeat (3) @(negedge clk);
    chk("R2", sb.size(), 0, "leftover expected items");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule